// File: doc/BRIEF.md
# Inter-Processor Mailbox

This block lets a host processor exchange short messages with up to three peer processors over a single 32-bit register bus. Each link joins the host to one peer and has two ends. The host end is an inbox read by the host, and the peer end is an inbox read by that peer. Every end holds eight info words and a doorbell register. A sender writes its payload into the far end's info words, then rings that end's doorbell. The doorbell raises a sticky status bit owned by the receiving processor.

Software decides what the info words mean. Words 0 to 6 carry the payload, with a non-zero protocol word in word 0. Word 7 carries an acknowledge word, 0xDEADBEAF. The receiver zeroes word 0 once it has consumed a message. Doorbell bit 6 announces data and bit 7 announces an acknowledge. Both set the same status bit, so software tells them apart from the info words.

Each processor has its own status, clear and enable registers. Each processor also has one registered interrupt line, raised while any of its enabled status bits is set.

Top module: `ipc_mailbox`

## Requirements
- R1: The address is decoded as follows. Bit 15 selects the side: 0 is host, 1 is peer. Bits 13:12 select window w. Bit 14 and bits 1:0 must be zero. The host side has two kinds of window: window 0 holds the host controls, and window k (1..3) is the host inbox for link k. On the peer side, window k is peer k's own window. Word offsets within a window are: status 0x00, clear 0x04, enable 0x0C, doorbell 0x10, and info word i at 0x14+4*i.
- R2: Each inbox (host window k, peer window k) stores its own eight info words. A write is readable in the following cycle, and writing one inbox leaves every other inbox unchanged.
- R3: Reset clears all status, enable and info registers and drives every interrupt line low.
- R4: Writing the doorbell of an inbox with bit 6 or bit 7 set sets the owner's status bit. For host inbox k this is host status bit k-1; for peer window k it is that peer's status bit 0. A doorbell write with neither bit set changes nothing.
- R5: A status bit stays set until software writes a 1 to the matching bit of its owner's clear register. Zero bits leave status unchanged, and writing 0xFF clears every host bit.
- R6: The host interrupt line is the registered OR of (host status AND host enable). It follows the status one cycle later. The host enable register holds one bit per link and reads back only those bits.
- R7: The doorbell and clear offsets always read as zero.
- R8: Unmapped accesses read zero and writes to them change nothing. These are: bit 14 set, misaligned addresses, peer-side window 0, control offsets in host inbox windows, info or doorbell offsets in host window 0, and any other offset.
- R9: Interrupt line k (k = 1..3) is the registered AND of peer k's status bit and peer k's enable bit 0. It is independent of all other ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 16 | Register byte address |
| busWe | input | 1 | Write enable for the current cycle |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for busAddr, combinational |
| irq | output | 4 | Interrupt lines: bit 0 host, bit k peer k |

## Verification
The hardest situation to reach is a doorbell or clear aimed at one end while other ends already hold state. Only then does a wrong end index show up as a stray status bit, a stray interrupt, or a clear that hits the wrong bit. The stimulus first fills several inboxes and sets status in both the host and a peer. It then clears single bits and re-reads neighbouring ends. After that it rings a peer whose enable is off, and enables it later to watch the interrupt rise without a new doorbell.

// File: rtl/mbox_pkg.sv
`timescale 1ns/1ps
package mbox_pkg;
  localparam int INFO_WORDS  = 8;
  localparam int WORD_W      = $clog2(INFO_WORDS);
  localparam int LINK_W      = 4;
  // word index (byte offset / 4) inside a window
  localparam int IDX_STAT    = 0;
  localparam int IDX_CLR     = 1;
  localparam int IDX_EN      = 3;
  localparam int IDX_BELL    = 4;
  localparam int IDX_INFO0   = 5;
  localparam int BELL_DATA   = 6;
  localparam int BELL_ACK    = 7;

  typedef enum logic [1:0] {RD_NONE, RD_STAT, RD_EN, RD_INFO} rdKind_e;

  typedef struct packed {
    logic              peerSide;
    logic [LINK_W-1:0] link;
    logic [WORD_W-1:0] word;
    logic              infoWe;
    logic              bellWe;
    logic              clrWe;
    logic              enWe;
    rdKind_e           rdKind;
  } mboxStrobe_t;
endpackage

// File: rtl/mbox_decode.sv
`timescale 1ns/1ps
module mbox_decode
  import mbox_pkg::*;
#(
  parameter int NLINK  = 3,
  parameter int ADDR_W = 16
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  output mboxStrobe_t       strobe
);
  localparam int WIN_W = $clog2(NLINK + 1);

  logic             side, clean, inRange;
  logic             ctlWin, inboxWin, peerWin, linkWin, ownCtl;
  logic [WIN_W-1:0] win;
  logic [9:0]       wordIdx;

  always_comb begin
    side     = busAddr[ADDR_W-1];
    win      = busAddr[12 +: WIN_W];
    wordIdx  = busAddr[11:2];
    clean    = (busAddr[1:0] == 2'b00) && (busAddr[ADDR_W-2:12+WIN_W] == '0);
    inRange  = ({1'b0, win} <= (WIN_W+1)'(NLINK));
    ctlWin   = clean && !side && (win == '0);
    inboxWin = clean && !side && (win != '0) && inRange;
    peerWin  = clean &&  side && (win != '0) && inRange;
    linkWin  = inboxWin || peerWin;
    ownCtl   = ctlWin || peerWin;

    strobe          = '0;
    strobe.peerSide = side;
    strobe.link     = LINK_W'(win - WIN_W'(1));
    strobe.word     = WORD_W'(wordIdx - 10'(IDX_INFO0));
    strobe.rdKind   = RD_NONE;

    if (ownCtl && wordIdx == 10'(IDX_STAT)) strobe.rdKind = RD_STAT;
    if (ownCtl && wordIdx == 10'(IDX_CLR))  strobe.clrWe  = busWe;
    if (ownCtl && wordIdx == 10'(IDX_EN)) begin
      strobe.rdKind = RD_EN;
      strobe.enWe   = busWe;
    end
    if (linkWin && wordIdx == 10'(IDX_BELL)) strobe.bellWe = busWe;
    if (linkWin && wordIdx >= 10'(IDX_INFO0) &&
        wordIdx < 10'(IDX_INFO0 + INFO_WORDS)) begin
      strobe.rdKind = RD_INFO;
      strobe.infoWe = busWe;
    end
  end
endmodule

// File: rtl/mbox_regs.sv
`timescale 1ns/1ps
module mbox_regs
  import mbox_pkg::*;
#(
  parameter int NLINK  = 3,
  parameter int DATA_W = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  mboxStrobe_t          strobe,
  input  logic [DATA_W-1:0]    wrData,
  output logic [DATA_W-1:0]    rdData,
  output logic [NLINK:0]       irq,
  output logic [2*NLINK-1:0]   statVec,
  output logic [2*NLINK-1:0]   maskVec
);
  localparam int NEND  = 2 * NLINK;
  localparam int END_W = $clog2(NEND);

  logic [DATA_W-1:0] infoMem [NEND][INFO_WORDS];
  logic [NEND-1:0]   statQ, enQ, setVec, clrVec, enNext;
  logic [END_W-1:0]  endSel;

  always_comb begin
    endSel = END_W'(strobe.link) + (strobe.peerSide ? END_W'(NLINK) : END_W'(0));

    setVec = '0;
    if (strobe.bellWe && (wrData[BELL_DATA] || wrData[BELL_ACK]))
      setVec[endSel] = 1'b1;

    clrVec = '0;
    enNext = enQ;
    if (strobe.peerSide) begin
      if (strobe.clrWe) clrVec[endSel] = wrData[0];
      if (strobe.enWe)  enNext[endSel] = wrData[0];
    end else begin
      if (strobe.clrWe) clrVec[NLINK-1:0] = wrData[NLINK-1:0];
      if (strobe.enWe)  enNext[NLINK-1:0] = wrData[NLINK-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statQ <= '0;
      enQ   <= '0;
      irq   <= '0;
    end else begin
      statQ  <= (statQ & ~clrVec) | setVec;
      enQ    <= enNext;
      irq[0] <= |(statQ[NLINK-1:0] & enQ[NLINK-1:0]);
      for (int k = 1; k <= NLINK; k++)
        irq[k] <= statQ[NLINK+k-1] & enQ[NLINK+k-1];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int e = 0; e < NEND; e++)
        for (int w = 0; w < INFO_WORDS; w++)
          infoMem[e][w] <= '0;
    end else if (strobe.infoWe) begin
      infoMem[endSel][strobe.word] <= wrData;
    end
  end

  always_comb begin
    rdData = '0;
    unique case (strobe.rdKind)
      RD_STAT: rdData = strobe.peerSide ? DATA_W'(statQ[endSel]) : DATA_W'(statQ[NLINK-1:0]);
      RD_EN:   rdData = strobe.peerSide ? DATA_W'(enQ[endSel])   : DATA_W'(enQ[NLINK-1:0]);
      RD_INFO: rdData = infoMem[endSel][strobe.word];
      default: rdData = '0;
    endcase
  end

  assign statVec = statQ;
  assign maskVec = enQ;
endmodule

// File: rtl/ipc_mailbox.sv
`timescale 1ns/1ps
module ipc_mailbox
  import mbox_pkg::*;
#(
  parameter int NPROC  = 4,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic [NPROC-1:0]  irq
);
  localparam int NLINK = NPROC - 1;

  mboxStrobe_t        strobe;
  logic [2*NLINK-1:0] statVec;
  logic [2*NLINK-1:0] maskVec;

  mbox_decode #(.NLINK(NLINK), .ADDR_W(ADDR_W)) u_dec (
    .busAddr (busAddr),
    .busWe   (busWe),
    .strobe  (strobe)
  );

  mbox_regs #(.NLINK(NLINK), .DATA_W(DATA_W)) u_regs (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .wrData  (busWdata),
    .rdData  (busRdata),
    .irq     (irq),
    .statVec (statVec),
    .maskVec (maskVec)
  );
endmodule

// File: rtl/mbox_checker.sv
`timescale 1ns/1ps
module mbox_checker #(
  parameter int NPROC  = 4,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input logic                   clk,
  input logic                   rstN,
  input logic [ADDR_W-1:0]      busAddr,
  input logic                   busWe,
  input logic [DATA_W-1:0]      busWdata,
  input logic [DATA_W-1:0]      busRdata,
  input logic [NPROC-1:0]       irq,
  input logic [2*(NPROC-1)-1:0] statVec,
  input logic [2*(NPROC-1)-1:0] maskVec
);
  localparam int NLINK = NPROC - 1;

  // R5: without a clear write, no status bit drops
  a_r5_sticky: assert property (@(posedge clk) disable iff (!rstN)
    !(busWe && busAddr[11:0] == 12'h004) |=> ((statVec & $past(statVec)) == $past(statVec)))
    else $error("status bit dropped without clear");

  // R4: a new status bit needs a doorbell write with bit 6 or 7 one cycle earlier
  a_r4_set_needs_bell: assert property (@(posedge clk) disable iff (!rstN)
    ((statVec & ~$past(statVec)) != '0) |->
      $past(busWe && busAddr[11:0] == 12'h010 && busWdata[7:6] != 2'b00))
    else $error("status set without doorbell");

  // R6: host line follows enabled host status by one cycle
  a_r6_host_irq: assert property (@(posedge clk) disable iff (!rstN)
    irq[0] == $past(|(statVec[NLINK-1:0] & maskVec[NLINK-1:0])))
    else $error("host interrupt mismatch");

  // R7: doorbell offset reads zero
  a_r7_bell_reads_zero: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr[11:0] == 12'h010) |-> (busRdata == '0))
    else $error("doorbell read non-zero");

  // R8: bit 14 set is unmapped
  a_r8_upper_unmapped: assert property (@(posedge clk) disable iff (!rstN)
    busAddr[ADDR_W-2] |-> (busRdata == '0))
    else $error("unmapped read non-zero");

  for (genvar k = 1; k < NPROC; k++) begin : g_peer
    // R9: each peer line follows only its own status and enable
    a_r9_peer_irq: assert property (@(posedge clk) disable iff (!rstN)
      irq[k] == $past(statVec[NLINK+k-1] & maskVec[NLINK+k-1]))
      else $error("peer interrupt mismatch");
  end
endmodule

bind ipc_mailbox mbox_checker #(.NPROC(NPROC), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/sim_ipc_mailbox.sv
`timescale 1ns/1ps
module sim_ipc_mailbox;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] busAddr = '0;
  logic        busWe = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [3:0]  irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  ipc_mailbox u0 (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .busRdata(busRdata), .irq(irq)
  );

  // {tag, write, address, write data, expected read}
  localparam int NV = 42;
  localparam logic [84:0] VEC [NV] = '{
    {4'd3, 1'b0, 16'h0000, 32'h0,        32'h0},        // R3 host status
    {4'd3, 1'b0, 16'h000C, 32'h0,        32'h0},        // R3 host enable
    {4'd2, 1'b1, 16'h9014, 32'h12345678, 32'h0},        // R2 peer1 word0
    {4'd2, 1'b0, 16'h9014, 32'h0,        32'h12345678},
    {4'd2, 1'b1, 16'h902C, 32'hCAFE0006, 32'h0},        // R2 peer1 word6
    {4'd2, 1'b0, 16'h902C, 32'h0,        32'hCAFE0006},
    {4'd2, 1'b1, 16'h9030, 32'hDEADBEAF, 32'h0},        // R2 ack word
    {4'd2, 1'b0, 16'h9030, 32'h0,        32'hDEADBEAF},
    {4'd1, 1'b0, 16'h1014, 32'h0,        32'h0},        // R1 host inbox1 separate
    {4'd1, 1'b1, 16'h1014, 32'hA5A5A5A5, 32'h0},
    {4'd1, 1'b0, 16'h1014, 32'h0,        32'hA5A5A5A5},
    {4'd1, 1'b0, 16'h9014, 32'h0,        32'h12345678}, // R1 peer1 untouched
    {4'd4, 1'b1, 16'h9010, 32'h00000040, 32'h0},        // R4 data doorbell
    {4'd4, 1'b0, 16'h9000, 32'h0,        32'h1},
    {4'd7, 1'b0, 16'h9010, 32'h0,        32'h0},        // R7 doorbell reads 0
    {4'd4, 1'b1, 16'h2010, 32'h00000080, 32'h0},        // R4 ack doorbell link2
    {4'd4, 1'b0, 16'h0000, 32'h0,        32'h2},
    {4'd4, 1'b1, 16'h3010, 32'h0000003F, 32'h0},        // R4 no bell bits
    {4'd4, 1'b0, 16'h0000, 32'h0,        32'h2},
    {4'd6, 1'b1, 16'h000C, 32'hFFFFFFFF, 32'h0},        // R6 enable width
    {4'd6, 1'b0, 16'h000C, 32'h0,        32'h7},
    {4'd5, 1'b1, 16'h0004, 32'h00000001, 32'h0},        // R5 clear other bit
    {4'd5, 1'b0, 16'h0000, 32'h0,        32'h2},
    {4'd5, 1'b1, 16'h1010, 32'h000000C0, 32'h0},        // R5 link1 both bits
    {4'd5, 1'b0, 16'h0000, 32'h0,        32'h3},
    {4'd5, 1'b1, 16'h0004, 32'h000000FF, 32'h0},        // R5 clear all
    {4'd5, 1'b0, 16'h0000, 32'h0,        32'h0},
    {4'd7, 1'b0, 16'h0004, 32'h0,        32'h0},        // R7 clear reads 0
    {4'd8, 1'b1, 16'h0008, 32'h0000FFFF, 32'h0},        // R8 gap offset
    {4'd8, 1'b0, 16'h0008, 32'h0,        32'h0},
    {4'd8, 1'b1, 16'h4014, 32'h00000055, 32'h0},        // R8 bit 14
    {4'd8, 1'b0, 16'h4014, 32'h0,        32'h0},
    {4'd8, 1'b1, 16'h8014, 32'h00000077, 32'h0},        // R8 peer window 0
    {4'd8, 1'b0, 16'h8014, 32'h0,        32'h0},
    {4'd8, 1'b1, 16'h9016, 32'h00000099, 32'h0},        // R8 misaligned
    {4'd8, 1'b0, 16'h9014, 32'h0,        32'h12345678},
    {4'd8, 1'b0, 16'h0014, 32'h0,        32'h0},        // R8 no info in ctl window
    {4'd8, 1'b0, 16'h1000, 32'h0,        32'h0},        // R8 no status in inbox
    {4'd5, 1'b1, 16'h9004, 32'h00000001, 32'h0},        // R5 peer clear
    {4'd5, 1'b0, 16'h9000, 32'h0,        32'h0},
    {4'd2, 1'b1, 16'h9014, 32'h00000000, 32'h0},        // R2 receiver zeroes word0
    {4'd2, 1'b0, 16'h9014, 32'h0,        32'h0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wrReg(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWe = 1'b1;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic rdChk(input string req, input logic [15:0] a, input logic [31:0] exp);
    @(negedge clk);
    busWe = 1'b0; busAddr = a;
    #1;
    check(req, busRdata, exp);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    check("R3 irq after reset", 32'(irq), 32'h0);

    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("R%0d vec%0d", VEC[i][84:81], i);
      if (VEC[i][80]) wrReg(VEC[i][79:64], VEC[i][63:32]);
      else rdChk(tag, VEC[i][79:64], VEC[i][31:0]);
    end

    // R6: host line lags status by one cycle, drops after clear
    check("R6 host idle", 32'(irq[0]), 32'h0);
    wrReg(16'h1010, 32'h40);
    check("R6 host lag", 32'(irq[0]), 32'h0);
    @(negedge clk);
    check("R6 host raised", 32'(irq[0]), 32'h1);
    check("R9 peer1 quiet", 32'(irq[1]), 32'h0);
    wrReg(16'h0004, 32'h1);
    @(negedge clk);
    check("R6 host dropped", 32'(irq[0]), 32'h0);

    // R9: peer lines are independent
    wrReg(16'h900C, 32'h1);
    wrReg(16'h9010, 32'h80);
    @(negedge clk);
    check("R9 peer1 raised", 32'(irq[1]), 32'h1);
    check("R9 peer2 quiet", 32'(irq[2]), 32'h0);
    check("R9 host quiet", 32'(irq[0]), 32'h0);
    wrReg(16'hA010, 32'h40);
    @(negedge clk);
    check("R9 peer2 disabled", 32'(irq[2]), 32'h0);
    rdChk("R4 peer2 status", 16'hA000, 32'h1);
    wrReg(16'hA00C, 32'h1);
    @(negedge clk);
    check("R9 peer2 enabled", 32'(irq[2]), 32'h1);
    check("R9 peer3 quiet", 32'(irq[3]), 32'h0);

    // R3: reset in the middle of traffic
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    check("R3 irq cleared", 32'(irq), 32'h0);
    rdChk("R3 info cleared", 16'h1014, 32'h0);
    rdChk("R3 peer status cleared", 16'h9000, 32'h0);
    rdChk("R3 peer enable cleared", 16'h900C, 32'h0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule